// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into the timing strobes a serial link needs. A UART channel emits a one-cycle oversample strobe at sixteen times the bit rate, plus a bit strobe on every sixteenth oversample strobe. An infrared channel of the same structure emits one strobe per base period, for a base clock near 1.8432 MHz, with no x16 stage after it.

Each channel divides by an integer count plus a correction of 0 to 15 sixteenths. The correction comes from a small accumulator. Each base period it adds the 4-bit correction index. Each time the sum carries past 16, that period is one clock longer. Over sixteen base periods, exactly `index` of them are stretched. A UART bit therefore spans 16*(count+1)+index clocks, and sixteen infrared periods span 16*(count+1)+index clocks.

Software programs the block by writing 16-bit words. A zero count in the infrared channel is an illegal setting. It is flagged, and that channel stays silent.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and afterwards, no strobe is produced until `en` is high. Reset leaves both counts and both correction indices at zero, so `ir_cfg_err` reads 1. If enabled with these defaults, the UART channel strobes on every cycle.
- R2: With a correction index of 0, UART oversample strobes are one cycle wide and recur every count+1 cycles. The first strobe appears count cycles after the first cycle of counting.
- R3: Base period k of a channel (k counted from 0 after a restart) lasts count+1 cycles, plus one extra cycle when the accumulator carries. The accumulator starts at 0 and adds the index each period, modulo 16. The carry occurs when acc+index ≥ 16.
- R4: The correction index is taken from bits [7:4] of the written word. Bits [3:0] and [15:8] of a correction write have no effect.
- R5: `bit_tick` is high together with the 16th, 32nd, … oversample strobe counted from a restart, and at no other time.
- R6: The infrared channel follows R3 using its own count and index. Its count is bits [3:0] of the written word; bits [15:4] have no effect.
- R7: When the infrared count is 0, `ir_cfg_err` is 1 and `ir_tick` stays low. When the count is nonzero, `ir_cfg_err` is 0.
- R8: A write to a channel's count or correction register restarts that channel at the capturing edge. Counter, accumulator and bit counter return to zero, and the next cycle is cycle 0 of the first period.
- R9: While `en` is low, both channels are held at zero and produce no strobe. The first cycle with `en` high is cycle 0 of the first period.
- R10: Register select `wr_addr` uses 0 for the UART count, 1 for the UART correction, 2 for the infrared count and 3 for the infrared correction. A write to one channel neither changes nor restarts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Divider enable for both channels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write word |
| os_tick | output | 1 | UART oversample strobe |
| bit_tick | output | 1 | UART bit strobe |
| ir_tick | output | 1 | Infrared base-clock strobe |
| ir_cfg_err | output | 1 | Infrared count is zero (illegal) |

## Verification
Strobes are combinational from registered state. After a write captured at an edge, or after `en` rises, the strobe that ends period 0 is high in the cycle count+stretch0 cycles later. Each following strobe lands count+1+stretch_k cycles after the previous one. `ir_cfg_err` follows a count write in the cycle right after the capturing edge. The bench drives inputs just after a rising edge, reads the cycle number of the capturing edge, and queues the exact cycle of every expected strobe. A monitor samples at the falling edge and pops the queue on every strobe it sees inside the planned window. At the end of the window the queue must be empty.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  localparam logic [1:0] SEL_U_CNT  = 2'd0;
  localparam logic [1:0] SEL_U_FRAC = 2'd1;
  localparam logic [1:0] SEL_I_CNT  = 2'd2;
  localparam logic [1:0] SEL_I_FRAC = 2'd3;

  function automatic logic sel_is_uart(input logic [1:0] sel);
    return (sel == SEL_U_CNT) || (sel == SEL_U_FRAC);
  endfunction
endpackage

// File: rtl/fbd_regs.sv
module fbd_regs #(
  parameter int DATA_W   = 16,
  parameter int UCNT_W   = 16,
  parameter int ICNT_W   = 4,
  parameter int FRAC_W   = 4,
  parameter int FRAC_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [UCNT_W-1:0] ucnt,
  output logic [FRAC_W-1:0] ufrac,
  output logic [ICNT_W-1:0] icnt,
  output logic [FRAC_W-1:0] ifrac,
  output logic              u_restart,
  output logic              i_restart,
  output logic              ir_bad
);
  import fbd_pkg::*;

  logic [UCNT_W-1:0] ucnt_d;
  logic [FRAC_W-1:0] ufrac_d, ifrac_d;
  logic [ICNT_W-1:0] icnt_d;
  logic              ld_ucnt, ld_ufrac, ld_icnt, ld_ifrac;

  always_comb begin
    ld_ucnt  = wr_en && (wr_addr == SEL_U_CNT);
    ld_ufrac = wr_en && (wr_addr == SEL_U_FRAC);
    ld_icnt  = wr_en && (wr_addr == SEL_I_CNT);
    ld_ifrac = wr_en && (wr_addr == SEL_I_FRAC);
    ucnt_d   = ld_ucnt  ? wr_data[UCNT_W-1:0] : ucnt;
    ufrac_d  = ld_ufrac ? wr_data[FRAC_LSB +: FRAC_W] : ufrac;
    icnt_d   = ld_icnt  ? wr_data[ICNT_W-1:0] : icnt;
    ifrac_d  = ld_ifrac ? wr_data[FRAC_LSB +: FRAC_W] : ifrac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt  <= '0;
      ufrac <= '0;
      icnt  <= '0;
      ifrac <= '0;
    end else begin
      ucnt  <= ucnt_d;
      ufrac <= ufrac_d;
      icnt  <= icnt_d;
      ifrac <= ifrac_d;
    end
  end

  assign u_restart = wr_en && sel_is_uart(wr_addr);
  assign i_restart = wr_en && !sel_is_uart(wr_addr);
  assign ir_bad    = (icnt == '0);

  p_frac_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_U_FRAC) |=> (ufrac == $past(wr_data[FRAC_LSB +: FRAC_W])));

  p_ir_cnt_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_I_CNT) |=> (icnt == $past(wr_data[ICNT_W-1:0])));

  p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ucnt) && $stable(ufrac) && $stable(icnt) && $stable(ifrac)));
endmodule

// File: rtl/fbd_core.sv
module fbd_core #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CNT_W-1:0]  cnt_cfg,
  input  logic [FRAC_W-1:0] frac_cfg,
  output logic              tick
);
  localparam int CW = CNT_W + 1;
  localparam int SW = FRAC_W + 1;

  logic [CW-1:0]     cnt_q, cnt_d, lim;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [SW-1:0]     sum;
  logic              stretch, at_end;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, frac_cfg};
    stretch = sum[FRAC_W];
    lim     = {1'b0, cnt_cfg} + {{(CW-1){1'b0}}, stretch};
    at_end  = (cnt_q == lim);
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    if (restart || !run) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
      acc_d = sum[FRAC_W-1:0];
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign tick = run && at_end;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ({1'b0, cnt_cfg} + 1'b1));

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && (cnt_cfg != '0)) |=> !tick);
endmodule

// File: rtl/fbd_bitdiv.sv
module fbd_bitdiv #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic os_tick,
  output logic bit_tick
);
  localparam int BW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [BW-1:0] LAST = BW'(RATIO - 1);

  logic [BW-1:0] bcnt_q, bcnt_d;

  always_comb begin
    bcnt_d = bcnt_q;
    if (clr)            bcnt_d = '0;
    else if (os_tick)   bcnt_d = (bcnt_q == LAST) ? '0 : bcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  assign bit_tick = os_tick && (bcnt_q == LAST);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DATA_W      = 16,
  parameter int UCNT_W      = 16,
  parameter int ICNT_W      = 4,
  parameter int FRAC_W      = 4,
  parameter int FRAC_LSB    = 4,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              ir_tick,
  output logic              ir_cfg_err
);
  logic              rst_sync_n;
  logic [UCNT_W-1:0] ucnt;
  logic [FRAC_W-1:0] ufrac, ifrac;
  logic [ICNT_W-1:0] icnt;
  logic              u_restart, i_restart, ir_bad;
  logic              u_run, i_run;

  if (SYNC_STAGES <= 1) begin : g_sync1
    logic s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_q <= 1'b0;
      else        s_q <= 1'b1;
    end
    assign rst_sync_n = s_q;
  end else begin : g_syncn
    logic [SYNC_STAGES-1:0] s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_q <= '0;
      else        s_q <= {s_q[SYNC_STAGES-2:0], 1'b1};
    end
    assign rst_sync_n = s_q[SYNC_STAGES-1];
  end

  fbd_regs #(
    .DATA_W(DATA_W), .UCNT_W(UCNT_W), .ICNT_W(ICNT_W),
    .FRAC_W(FRAC_W), .FRAC_LSB(FRAC_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ucnt(ucnt), .ufrac(ufrac), .icnt(icnt),
    .ifrac(ifrac), .u_restart(u_restart), .i_restart(i_restart),
    .ir_bad(ir_bad)
  );

  assign u_run = en && rst_sync_n;
  assign i_run = en && rst_sync_n && !ir_bad;

  fbd_core #(.CNT_W(UCNT_W), .FRAC_W(FRAC_W)) u_uart_div (
    .clk(clk), .rst_n(rst_sync_n), .run(u_run), .restart(u_restart),
    .cnt_cfg(ucnt), .frac_cfg(ufrac), .tick(os_tick)
  );

  fbd_bitdiv #(.RATIO(OSR)) u_bitdiv (
    .clk(clk), .rst_n(rst_sync_n), .clr(u_restart || !u_run),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  fbd_core #(.CNT_W(ICNT_W), .FRAC_W(FRAC_W)) u_ir_div (
    .clk(clk), .rst_n(rst_sync_n), .run(i_run), .restart(i_restart),
    .cnt_cfg(icnt), .frac_cfg(ifrac), .tick(ir_tick)
  );

  assign ir_cfg_err = ir_bad;

  p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_tick |-> os_tick);

  p_ir_bad_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ir_cfg_err |-> !ir_tick);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |-> (!os_tick && !ir_tick && !bit_tick));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!os_tick && !ir_tick));
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n, en, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        os_tick, bit_tick, ir_tick, ir_cfg_err;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int q_os[$];
  int q_bit[$];
  int q_ir[$];
  int u_lo = 32'h7fffffff, u_hi = -1;
  int i_lo = 32'h7fffffff, i_hi = -1;
  string u_tag = "", i_tag = "";

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick),
    .ir_tick(ir_tick), .ir_cfg_err(ir_cfg_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected strobe cycles inside the open windows
  always @(negedge clk) begin
    if (cyc >= u_lo && cyc <= u_hi) begin
      if (os_tick) begin
        if (q_os.size() == 0) chk(0, u_tag, "unexpected os_tick at cycle", cyc, -1);
        else begin
          int e;
          e = q_os.pop_front();
          chk(e == cyc, u_tag, "os_tick cycle", cyc, e);
        end
      end
      if (bit_tick) begin
        if (q_bit.size() == 0) chk(0, u_tag, "unexpected bit_tick (R5) at cycle", cyc, -1);
        else begin
          int e;
          e = q_bit.pop_front();
          chk(e == cyc, u_tag, "bit_tick cycle (R5)", cyc, e);
        end
      end
    end
    if (cyc >= i_lo && cyc <= i_hi) begin
      if (ir_tick) begin
        if (q_ir.size() == 0) chk(0, i_tag, "unexpected ir_tick at cycle", cyc, -1);
        else begin
          int e;
          e = q_ir.pop_front();
          chk(e == cyc, i_tag, "ir_tick cycle", cyc, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, output int c0);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    c0 = cyc;
  endtask

  // expected strobe cycles per R3: period k = n+1 (+1 on accumulator carry)
  task automatic plan_u(input int c0, input int n, input int idx, input int nper,
                        input string tag);
    int acc, t;
    q_os.delete(); q_bit.delete();
    acc = 0; t = c0 - 1;
    for (int k = 0; k < nper; k++) begin
      int s;
      s = ((acc + idx) >= 16) ? 1 : 0;
      acc = (acc + idx) % 16;
      t = t + n + 1 + s;
      q_os.push_back(t);
      if ((k % 16) == 15) q_bit.push_back(t);
    end
    u_tag = tag; u_lo = c0; u_hi = t;
  endtask

  task automatic plan_i(input int c0, input int n, input int idx, input int nper,
                        input string tag);
    int acc, t;
    q_ir.delete();
    acc = 0; t = c0 - 1;
    for (int k = 0; k < nper; k++) begin
      int s;
      s = ((acc + idx) >= 16) ? 1 : 0;
      acc = (acc + idx) % 16;
      t = t + n + 1 + s;
      q_ir.push_back(t);
    end
    i_tag = tag; i_lo = c0; i_hi = t;
  endtask

  task automatic quiet_u(input int c0, input int len, input string tag);
    q_os.delete(); q_bit.delete();
    u_tag = tag; u_lo = c0; u_hi = c0 + len - 1;
  endtask

  task automatic quiet_i(input int c0, input int len, input string tag);
    q_ir.delete();
    i_tag = tag; i_lo = c0; i_hi = c0 + len - 1;
  endtask

  task automatic close_u();
    while (cyc <= u_hi) @(negedge clk);
    chk(q_os.size() == 0, u_tag, "os_tick strobes missing", q_os.size(), 0);
    chk(q_bit.size() == 0, u_tag, "bit_tick strobes missing (R5)", q_bit.size(), 0);
    u_lo = 32'h7fffffff; u_hi = -1;
  endtask

  task automatic close_i();
    while (cyc <= i_hi) @(negedge clk);
    chk(q_ir.size() == 0, i_tag, "ir_tick strobes missing", q_ir.size(), 0);
    i_lo = 32'h7fffffff; i_hi = -1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int c0, c1;
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!os_tick && !ir_tick && !bit_tick, "R1", "strobes during reset", os_tick, 0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk(ir_cfg_err == 1'b1, "R1", "ir_cfg_err after reset", ir_cfg_err, 1);
    chk(!os_tick && !ir_tick, "R1", "strobes with en low after reset", os_tick, 0);

    // R1 defaults: UART strobes every cycle; R7 infrared silent
    @(posedge clk); #1; en = 1'b1; c0 = cyc;
    plan_u(c0, 0, 0, 20, "R1");
    quiet_i(c0, 20, "R7");
    close_u(); close_i();

    // R2 integer divide, R5 bit strobes, R10 addressing
    wr(2'd0, 16'd3, c0);
    plan_u(c0, 3, 0, 40, "R2");
    close_u();

    // R3 R4: index 8 in bits [7:4], low nibble ignored
    wr(2'd0, 16'd2, c0);
    wr(2'd1, 16'h0083, c0);
    plan_u(c0, 2, 8, 32, "R3 R4");
    close_u();

    // R3 R4: index 15, upper byte ignored
    wr(2'd1, 16'hA5F0, c0);
    plan_u(c0, 2, 15, 32, "R3 R4");
    close_u();

    // R10 + R6: infrared writes do not disturb a running UART channel
    wr(2'd0, 16'd4, c0);
    plan_u(c0, 4, 15, 40, "R10");
    wr(2'd2, 16'hFFF3, c1);
    wr(2'd3, 16'h0050, c1);
    chk(ir_cfg_err == 1'b0, "R7", "ir_cfg_err with legal count", ir_cfg_err, 0);
    plan_i(c1, 3, 5, 32, "R6");
    close_i(); close_u();

    // R8: rewrite mid-period restarts phase
    wr(2'd0, 16'd4, c0);
    repeat (7) @(posedge clk);
    wr(2'd0, 16'd4, c1);
    plan_u(c1, 4, 15, 20, "R8");
    close_u();

    // R9: disabled channels are silent, enabling starts at cycle 0
    @(posedge clk); #1; en = 1'b0; c0 = cyc;
    quiet_u(c0, 30, "R9");
    quiet_i(c0, 30, "R9");
    close_u(); close_i();
    @(posedge clk); #1; en = 1'b1; c0 = cyc;
    plan_u(c0, 4, 15, 20, "R9");
    plan_i(c0, 3, 5, 20, "R9");
    close_u(); close_i();

    // R7: zero infrared count is flagged and silent
    wr(2'd2, 16'hFFF0, c0);
    chk(ir_cfg_err == 1'b1, "R7", "ir_cfg_err with zero count", ir_cfg_err, 1);
    quiet_i(c0, 40, "R7");
    close_i();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule